// File: doc/BRIEF.md
# Unlock-Guarded Pin Multiplexing Register File

This block holds the pin multiplexing configuration for a bank of I/O pins and drives it out as static configuration vectors. It has five register groups. One selects, for each pin, whether the pin is a plain GPIO or is handed to a peripheral. One holds a 4-bit peripheral function code per pin. One holds a drive-strength code per pin. The last two hold a pull-enable bit and a pull-up/pull-down bit per pin. Software reaches the block over a simple 32-bit register bus with an address, a write strobe, write data and combinational read data.

The select, function and drive groups are guarded. A write to any of them lands only if the bus write just before it stored the bitwise complement of the same data into the key register at offset 0x000. Idle bus cycles in between do not matter. Every bus write uses up the pending unlock, whatever its address. A guarded write that fails the check is discarded and sets a sticky error flag, which software clears by writing 1 to it. The pull registers need no unlock.

Drive codes follow a 24 mA full scale. A 2-bit field steps in 6 mA and a 3-bit field steps in 3 mA. The stored code is the strength divided by the step, minus one.

Top module: `pinmux_guarded_regs`

## Requirements
- R1: After reset every register and every output vector is 0: all pins are GPIO, use function 0, have pulls off and drive code 0, and the error flag is clear.
- R2: The key register sits at address 0x000 and always reads as 0. Writing it arms the unlock and records the complement of the written data. A second key write re-arms the unlock with its own value.
- R3: A guarded write commits when the unlock is armed and its data equals the recorded complement. Any number of idle cycles (no write strobe) may separate the key write and the guarded write.
- R4: A guarded write that is not armed, or whose data does not match, changes no register and sets the error flag, bit 0 of address 0x004.
- R5: Every write other than a key write disarms the unlock. This includes pull, status, unmapped and failed guarded writes, so a guarded write after any of them is dropped.
- R6: The select word k is at 0x100+4k. Pin n is bit n%32 of word n/32, where 1 means peripheral and 0 means GPIO. It drives periph_sel[n].
- R7: The function word k is at 0x200+4k. Pin n uses bits 4*(n%8)+3 down to 4*(n%8) of word n/8, and drives func_sel[4n+3:4n].
- R8: The drive word k is at 0x300+4k. Pin n uses the DRV_BITS low bits of the nibble at 4*(n%8) of word n/8, and drives drive_code[n*DRV_BITS +: DRV_BITS]. All other bits of a drive word are dropped on write and read as 0.
- R9: The pull-enable word k is at 0x400+4k and the pull-up word k is at 0x500+4k. Pin n is bit n%32 of word n/32, where 1 means enabled or pull-up. Both are written with no unlock and never touch the error flag.
- R10: A write to 0x004 with bit 0 set clears the error flag. A write with bit 0 clear leaves the flag as it is.
- R11: Reads are combinational and have no side effects. An address whose low two bits are not 00, an index beyond a group's word count, or an unmapped region reads 0, and writing there changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address |
| bus_wr_en | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| periph_sel | output | NUM_PINS | 1 = pin handed to a peripheral |
| func_sel | output | NUM_PINS*4 | Function code per pin |
| drive_code | output | NUM_PINS*DRV_BITS | Drive code per pin |
| pull_en | output | NUM_PINS | Pull enable per pin |
| pull_up | output | NUM_PINS | 1 = pull-up, 0 = pull-down |

## Verification
The bench targets the lifetime of the unlock. It puts idle gaps between the key write and the guarded write, which a design that timed out the unlock would wrongly reject. It puts a pull or status write in between, which a design that only disarmed on guarded writes would wrongly accept. It issues back-to-back key writes, which a design that kept the first value would commit wrongly. It also attempts guarded writes with mismatched data, beyond a group's word range and at misaligned addresses, and checks that none of them disturbs a neighbouring register. It checks that masked drive bits read back as zero and that the error flag survives a write of 0 but clears on a write of 1.

// File: rtl/pinmux_guard_pkg.sv
package pinmux_guard_pkg;
   localparam int ADDR_W = 12;

   typedef enum logic [3:0] {
      RG_CTRL  = 4'h0,
      RG_SEL   = 4'h1,
      RG_FUNC  = 4'h2,
      RG_DRV   = 4'h3,
      RG_PEN   = 4'h4,
      RG_PUP   = 4'h5
   } region_e;

   localparam logic [5:0] IDX_KEY    = 6'd0;
   localparam logic [5:0] IDX_STATUS = 6'd1;

   // keep the low drv_bits of every nibble
   function automatic logic [31:0] drive_mask(input int drv_bits);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < 8; i++)
         m[i*4 +: 4] = 4'((1 << drv_bits) - 1);
      return m;
   endfunction
endpackage

// File: rtl/pinmux_unlock_gate.sv
module pinmux_unlock_gate (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        is_key,
   input  logic        is_guarded,
   input  logic [31:0] wdata,
   output logic        commit,
   output logic        drop
);
   logic        armed_q;
   logic [31:0] expect_q;

   assign commit = wr_en & is_guarded & armed_q & (wdata == expect_q);
   assign drop   = wr_en & is_guarded & ~commit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q  <= 1'b0;
         expect_q <= '0;
      end else if (wr_en) begin
         armed_q <= is_key;
         if (is_key) expect_q <= ~wdata;
      end
   end

   // R5: any non-key write leaves the gate disarmed
   p_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !is_key) |=> !armed_q);
   // R2: a key write arms the gate with the complement
   p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && is_key) |=> (armed_q && expect_q == ~$past(wdata)));
   // R3: idle cycles keep the unlock
   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(armed_q) && $stable(expect_q)));
endmodule

// File: rtl/pinmux_word_bank.sv
module pinmux_word_bank #(
   parameter int          N_WORDS = 2,
   parameter logic [31:0] MASK    = 32'hFFFF_FFFF
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [5:0]            wr_idx,
   input  logic [31:0]           wr_data,
   input  logic [5:0]            rd_idx,
   output logic [31:0]           rd_data,
   output logic [N_WORDS*32-1:0] words_flat
);
   if (N_WORDS < 1 || N_WORDS > 64) begin : g_bad_depth
      $error("pinmux_word_bank: N_WORDS must lie in 1..64");
   end

   logic [31:0] words_q [N_WORDS];

   for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words_q[w] <= '0;
         else if (wr_en && wr_idx == 6'(w))
            words_q[w] <= wr_data & MASK;
      end
      assign words_flat[w*32 +: 32] = words_q[w];
   end

   always_comb begin
      rd_data = '0;
      for (int w = 0; w < N_WORDS; w++)
         if (rd_idx == 6'(w)) rd_data = words_q[w];
   end
endmodule

// File: rtl/pinmux_guarded_regs.sv
module pinmux_guarded_regs
   import pinmux_guard_pkg::*;
#(
   parameter int NUM_PINS = 64,
   parameter int DRV_BITS = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [11:0]                  bus_addr,
   input  logic                         bus_wr_en,
   input  logic [31:0]                  bus_wdata,
   output logic [31:0]                  bus_rdata,
   output logic [NUM_PINS-1:0]          periph_sel,
   output logic [NUM_PINS*4-1:0]        func_sel,
   output logic [NUM_PINS*DRV_BITS-1:0] drive_code,
   output logic [NUM_PINS-1:0]          pull_en,
   output logic [NUM_PINS-1:0]          pull_up
);
   localparam int          BIT_WORDS  = NUM_PINS / 32;
   localparam int          NIB_WORDS  = NUM_PINS / 8;
   localparam logic [31:0] DRV_MASK   = drive_mask(DRV_BITS);

   if (NUM_PINS % 32 != 0 || NUM_PINS < 32 || NUM_PINS > 512) begin : g_bad_pins
      $error("pinmux_guarded_regs: NUM_PINS must be a multiple of 32 in 32..512");
   end
   if (DRV_BITS != 2 && DRV_BITS != 3) begin : g_bad_drv
      $error("pinmux_guarded_regs: DRV_BITS must be 2 or 3");
   end
   if (ADDR_W != 12) begin : g_bad_addr
      $error("pinmux_guarded_regs: address map assumes 12 address bits");
   end

   // address decode
   logic       aligned;
   logic [3:0] region;
   logic [5:0] idx;
   logic       is_key, is_status, is_guarded;

   assign aligned    = (bus_addr[1:0] == 2'b00);
   assign region     = bus_addr[11:8];
   assign idx        = bus_addr[7:2];
   assign is_key     = aligned && region == RG_CTRL && idx == IDX_KEY;
   assign is_status  = aligned && region == RG_CTRL && idx == IDX_STATUS;
   assign is_guarded = aligned && (region == RG_SEL || region == RG_FUNC || region == RG_DRV);

   logic commit, drop;

   pinmux_unlock_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (bus_wr_en),
      .is_key     (is_key),
      .is_guarded (is_guarded),
      .wdata      (bus_wdata),
      .commit     (commit),
      .drop       (drop)
   );

   // error flag
   logic err_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         err_q <= 1'b0;
      else if (drop)
         err_q <= 1'b1;
      else if (bus_wr_en && is_status && bus_wdata[0])
         err_q <= 1'b0;
   end

   // register banks
   logic [31:0] rd_sel, rd_fn, rd_drv, rd_pen, rd_pup;
   logic [BIT_WORDS*32-1:0] sel_flat, pen_flat, pup_flat;
   logic [NIB_WORDS*32-1:0] fn_flat, drv_flat;

   pinmux_word_bank #(.N_WORDS(BIT_WORDS), .MASK(32'hFFFF_FFFF)) u_sel (
      .clk(clk), .rst_n(rst_n),
      .wr_en(commit && region == RG_SEL), .wr_idx(idx), .wr_data(bus_wdata),
      .rd_idx(idx), .rd_data(rd_sel), .words_flat(sel_flat));

   pinmux_word_bank #(.N_WORDS(NIB_WORDS), .MASK(32'hFFFF_FFFF)) u_fn (
      .clk(clk), .rst_n(rst_n),
      .wr_en(commit && region == RG_FUNC), .wr_idx(idx), .wr_data(bus_wdata),
      .rd_idx(idx), .rd_data(rd_fn), .words_flat(fn_flat));

   pinmux_word_bank #(.N_WORDS(NIB_WORDS), .MASK(DRV_MASK)) u_drv (
      .clk(clk), .rst_n(rst_n),
      .wr_en(commit && region == RG_DRV), .wr_idx(idx), .wr_data(bus_wdata),
      .rd_idx(idx), .rd_data(rd_drv), .words_flat(drv_flat));

   pinmux_word_bank #(.N_WORDS(BIT_WORDS), .MASK(32'hFFFF_FFFF)) u_pen (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_wr_en && aligned && region == RG_PEN), .wr_idx(idx), .wr_data(bus_wdata),
      .rd_idx(idx), .rd_data(rd_pen), .words_flat(pen_flat));

   pinmux_word_bank #(.N_WORDS(BIT_WORDS), .MASK(32'hFFFF_FFFF)) u_pup (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_wr_en && aligned && region == RG_PUP), .wr_idx(idx), .wr_data(bus_wdata),
      .rd_idx(idx), .rd_data(rd_pup), .words_flat(pup_flat));

   // output vectors
   assign periph_sel = sel_flat;
   assign func_sel   = fn_flat;
   assign pull_en    = pen_flat;
   assign pull_up    = pup_flat;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_drive
      assign drive_code[p*DRV_BITS +: DRV_BITS] = drv_flat[(p/8)*32 + 4*(p%8) +: DRV_BITS];
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (aligned) begin
         unique case (region)
            RG_SEL:  bus_rdata = rd_sel;
            RG_FUNC: bus_rdata = rd_fn;
            RG_DRV:  bus_rdata = rd_drv;
            RG_PEN:  bus_rdata = rd_pen;
            RG_PUP:  bus_rdata = rd_pup;
            RG_CTRL: bus_rdata = is_status ? {31'b0, err_q} : 32'b0;
            default: bus_rdata = '0;
         endcase
      end
   end

   // R4: guarded state only moves on a committed write
   p_guard_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(periph_sel) && $stable(func_sel) && $stable(drive_code)));
   // R4: a dropped write raises the error flag
   p_err_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> err_q);
   // R2: the key address always reads 0
   p_key_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 12'h000) |-> (bus_rdata == 32'b0));
   // R9: pull-enable writes land without unlock
   p_pull_direct_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && aligned && region == RG_PEN && int'(idx) < BIT_WORDS)
      |=> (pull_en[int'($past(idx))*32 +: 32] == $past(bus_wdata)));
   // R9: pull writes never touch the error flag
   p_pull_no_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && aligned && (region == RG_PEN || region == RG_PUP)) |=> $stable(err_q));
endmodule

// File: tb/pinmux_guarded_regs_tb_top.sv
module pinmux_guarded_regs_tb_top;
   localparam int NP = 64;
   localparam int DB = 3;
   localparam int BW = NP / 32;
   localparam int NW = NP / 8;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [11:0]        bus_addr = '0;
   logic               bus_wr_en = 1'b0;
   logic [31:0]        bus_wdata = '0;
   logic [31:0]        bus_rdata;
   logic [NP-1:0]      periph_sel, pull_en, pull_up;
   logic [NP*4-1:0]    func_sel;
   logic [NP*DB-1:0]   drive_code;

   always #10 clk = ~clk;

   pinmux_guarded_regs #(.NUM_PINS(NP), .DRV_BITS(DB)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_sel(periph_sel),
      .func_sel(func_sel), .drive_code(drive_code), .pull_en(pull_en), .pull_up(pull_up));

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   // reference model
   logic [31:0] m_sel [BW];
   logic [31:0] m_pen [BW];
   logic [31:0] m_pup [BW];
   logic [31:0] m_fn  [NW];
   logic [31:0] m_drv [NW];
   logic        m_err, m_armed;
   logic [31:0] m_key;

   function automatic logic [31:0] dmask();
      logic [31:0] m = '0;
      for (int i = 0; i < 8; i++) m[i*4 +: DB] = '1;
      return m;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < BW; i++) begin m_sel[i] = 0; m_pen[i] = 0; m_pup[i] = 0; end
      for (int i = 0; i < NW; i++) begin m_fn[i] = 0; m_drv[i] = 0; end
      m_err = 0; m_armed = 0; m_key = 0;
   endtask

   task automatic model_write(input logic [11:0] a, input logic [31:0] d);
      int rg = int'(a[11:8]);
      int ix = int'(a[7:2]);
      bit al = (a[1:0] == 0);
      bit key = al && rg == 0 && ix == 0;
      if (al && rg >= 1 && rg <= 3) begin
         if (m_armed && d == m_key) begin
            if (rg == 1 && ix < BW) m_sel[ix] = d;
            if (rg == 2 && ix < NW) m_fn[ix]  = d;
            if (rg == 3 && ix < NW) m_drv[ix] = d & dmask();
         end else m_err = 1;
      end else if (al && rg == 0 && ix == 1) begin
         if (d[0]) m_err = 0;
      end else if (al && rg == 4 && ix < BW) m_pen[ix] = d;
      else if (al && rg == 5 && ix < BW) m_pup[ix] = d;
      m_armed = key;
      if (key) m_key = ~d;
   endtask

   function automatic logic [31:0] model_read(input logic [11:0] a);
      int rg = int'(a[11:8]);
      int ix = int'(a[7:2]);
      if (a[1:0] != 0) return 0;
      case (rg)
         0: return (ix == 1) ? {31'b0, m_err} : 32'b0;
         1: return (ix < BW) ? m_sel[ix] : 32'b0;
         2: return (ix < NW) ? m_fn[ix]  : 32'b0;
         3: return (ix < NW) ? m_drv[ix] : 32'b0;
         4: return (ix < BW) ? m_pen[ix] : 32'b0;
         5: return (ix < BW) ? m_pup[ix] : 32'b0;
         default: return 0;
      endcase
   endfunction

   task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
      @(negedge clk);
      bus_wr_en = 1'b0;
      model_write(a, d);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic check_read(input string tag, input logic [11:0] a);
      bus_addr = a;
      #1;
      check32(tag, bus_rdata, model_read(a));
   endtask

   // R6 R7 R8 R9: output vectors against model
   task automatic check_vectors();
      for (int p = 0; p < NP; p++) begin
         check32("R6 periph_sel", 32'(periph_sel[p]), 32'(m_sel[p/32][p%32]));
         check32("R7 func_sel", 32'(func_sel[p*4 +: 4]), 32'(m_fn[p/8][4*(p%8) +: 4]));
         check32("R8 drive_code", 32'(drive_code[p*DB +: DB]), 32'(m_drv[p/8][4*(p%8) +: DB]));
         check32("R9 pull_en", 32'(pull_en[p]), 32'(m_pen[p/32][p%32]));
         check32("R9 pull_up", 32'(pull_up[p]), 32'(m_pup[p/32][p%32]));
      end
   endtask

   task automatic check_all_regs(input string tag);
      for (int r = 0; r < 6; r++)
         for (int i = 0; i < 10; i++)
            check_read(tag, 12'((r << 8) | (i << 2)));
   endtask

   function automatic logic [11:0] guarded_addr(input int rg, input int ix);
      return 12'((rg << 8) | (ix << 2));
   endfunction

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'h5EED_1234));
      model_reset();
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      check32("R1 periph_sel", 32'(|periph_sel), 0);
      check32("R1 func_sel", 32'(|func_sel), 0);
      check32("R1 drive_code", 32'(|drive_code), 0);
      check32("R1 pulls", 32'(|{pull_en, pull_up}), 0);
      check_all_regs("R1 readback");

      // R4 guarded write without unlock
      bus_write(12'h100, 32'hDEAD_BEEF);
      check_read("R4 dropped no key", 12'h100);
      check_read("R4 err flag set", 12'h004);
      // R10 write 0 keeps, write 1 clears
      bus_write(12'h004, 32'h0000_0000);
      check_read("R10 write0 keeps flag", 12'h004);
      bus_write(12'h004, 32'h0000_0001);
      check_read("R10 write1 clears flag", 12'h004);

      // R2 R3 correct unlock
      bus_write(12'h000, ~32'hA5A5_0F0F);
      check_read("R2 key reads zero", 12'h000);
      bus_write(12'h100, 32'hA5A5_0F0F);
      check_read("R3 commit select", 12'h100);
      check_vectors();

      // R3 idle gap keeps unlock
      bus_write(12'h000, ~32'h1234_5678);
      idle(7);
      bus_write(12'h204, 32'h1234_5678);
      check_read("R3 commit after idle", 12'h204);

      // R5 pull write between consumes unlock
      bus_write(12'h000, ~32'h0BAD_F00D);
      bus_write(12'h400, 32'hFFFF_0001);
      check_read("R9 pull en no unlock", 12'h400);
      bus_write(12'h300, 32'h0BAD_F00D);
      check_read("R5 dropped after pull", 12'h300);
      check_read("R5 err after pull", 12'h004);

      // R2 second key re-arms with its own value
      bus_write(12'h000, ~32'h1111_1111);
      bus_write(12'h000, ~32'h7654_3210);
      bus_write(12'h200, 32'h1111_1111);
      check_read("R2 old key rejected", 12'h200);
      bus_write(12'h000, ~32'h1111_1111);
      bus_write(12'h000, ~32'h7654_3210);
      bus_write(12'h200, 32'h7654_3210);
      check_read("R2 rearm commit", 12'h200);

      // R4 mismatched data
      bus_write(12'h000, ~32'h0000_00FF);
      bus_write(12'h104, 32'h0000_00FE);
      check_read("R4 mismatch dropped", 12'h104);

      // R8 drive masking
      bus_write(12'h000, ~32'hFFFF_FFFF);
      bus_write(12'h31C, 32'hFFFF_FFFF);
      check_read("R8 drive mask", 12'h31C);

      // R11 out of range and misaligned
      bus_write(12'h000, ~32'hCAFE_CAFE);
      bus_write(12'h108, 32'hCAFE_CAFE);
      bus_write(12'h402, 32'h5555_5555);
      bus_write(12'h50C, 32'h5555_5555);
      check_all_regs("R11 range/misalign");
      check_read("R11 misaligned read", 12'h101);
      check_vectors();

      // random mix
      for (int it = 0; it < 300; it++) begin
         int op = int'($urandom_range(0, 3));
         int rg = int'($urandom_range(1, 3));
         int ix = int'($urandom_range(0, 9));
         d = $urandom();
         case (op)
            0: begin bus_write(12'h000, ~d); bus_write(guarded_addr(rg, ix), d); end
            1: begin bus_write(12'h000, ~d); bus_write(guarded_addr(rg, ix), d ^ 32'h0000_0100); end
            2: bus_write(12'((int'($urandom_range(0, 6)) << 8) | (ix << 2)), d);
            default: begin
               bus_write(12'h000, ~d);
               idle(int'($urandom_range(1, 4)));
               bus_write(guarded_addr(rg, ix), d);
            end
         endcase
         check_read("R3 R4 R5 random", guarded_addr(rg, ix));
         if (it % 50 == 49) begin
            check_all_regs("R11 random readback");
            check_read("R4 R10 random status", 12'h004);
            check_vectors();
         end
      end
      summary();
   end
endmodule